// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the digital core of a two-wire (I2C) serial memory slave. It holds 256 bytes in 16 pages of 16 bytes. SCL and SDA are oversampled on the system clock, and the block finds START and STOP conditions in them. It accepts its device address and answers with acknowledge pulses through an open-drain pull-low enable. It serves byte writes, page writes, current-address reads, random reads and sequential reads.

Write data collects in a one-page staging buffer and reaches the array only when a clean STOP ends the write. A modelled internal write period, `BUSY_CYCLES` system clocks long, follows that STOP. During it the device address is not acknowledged, so a master can poll for completion. Two write guards are sampled once per write, just before the first data byte:
- a hardware write-protect pin;
- a permit line from an external protection unit.

States:
- `ST_IDLE`: bus free.
- `ST_DEV`: device byte coming in.
- `ST_ACK_DEV`: device byte acknowledged.
- `ST_WORD`: byte address coming in.
- `ST_ACK_WORD`: byte address acknowledged.
- `ST_WRDATA`: write data coming in.
- `ST_ACK_DATA`: data acknowledged.
- `ST_RDDATA`: read byte going out.
- `ST_RDACK`: master acknowledge slot.
- `ST_WAIT`: silent until the next START or STOP.

Transitions:
- A START leads from any state to `ST_DEV`. A STOP leads from any state to `ST_IDLE`.
- Each incoming byte moves on at the SCL fall that follows its eighth rising edge. `ST_DEV` goes to `ST_ACK_DEV` on an accepted address, otherwise to `ST_WAIT`. `ST_WORD` goes to `ST_ACK_WORD`. `ST_WRDATA` goes to `ST_ACK_DATA` when the write is permitted, otherwise to `ST_WAIT`.
- The acknowledge states move on at the falling edge that ends the ninth clock. `ST_ACK_DEV` goes to `ST_RDDATA` for a read and to `ST_WORD` for a write. `ST_ACK_WORD` and `ST_ACK_DATA` go to `ST_WRDATA`.
- `ST_RDDATA` goes to `ST_RDACK` after eight bits. `ST_RDACK` goes back to `ST_RDDATA` on a master ACK and to `ST_WAIT` on a NACK.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The device byte is accepted only when its upper seven bits are binary 1010 followed by `strap_i[2:0]` (MSB first); bit 0 is the direction, 1 = read, 0 = write. Any other device byte gets no acknowledge.
- R2: An accepted device byte, every byte address and every permitted write data byte is acknowledged by pulling SDA low during the ninth SCL clock.
- R3: A single byte written at a byte address lands at exactly that address; bits 7..4 of the address pick the page and bits 3..0 the byte inside it.
- R4: During a page write the in-page offset increments after each data byte and wraps from 15 to 0 inside the same page, so later bytes overwrite earlier ones; bytes outside the page are untouched and nothing reaches the array before the STOP.
- R5: After a STOP that ends a write with at least one accepted data byte, the device byte is not acknowledged for `BUSY_CYCLES` clocks; afterwards it is acknowledged again.
- R6: Between transfers the address counter points one past the last byte accessed (modulo 256). For a page write that is the page base plus the wrapped offset after the last byte. A read with no byte address returns the byte at that location.
- R7: A write carrying only a byte address, followed by a repeated START and a read request, reads from that byte address.
- R8: A read continues with the next address for as long as the master acknowledges, wrapping from 0xFF to 0x00; a master NACK ends the transfer.
- R9: `wp_i` is sampled at the SCL fall that ends the byte-address acknowledge. If it is high there, the first data byte gets no acknowledge, nothing is written and no busy period starts. A change of `wp_i` after that point has no effect on the write.
- R10: `wr_permit_i` is sampled at the same point as `wp_i`; when it is low there, the write is rejected exactly as in R9.
- R11: After reset every byte reads 0xFF and `sda_pull_o` is low.
- R12: A START or a STOP after two or more bit clocks of a byte discards all staged page data: the array is unchanged and no busy period starts.
- R13: `sda_pull_o` changes only while SCL is low, outside START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device-select straps compared with address bits 3..1 |
| wp_i | input | 1 | Hardware write protect, high blocks writes |
| wr_permit_i | input | 1 | Write permission from the protection unit, high allows writes |
| sda_pull_o | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
A wrong bit count or a wrong state shows on the very next acknowledge slot. The fault is either a missing or extra low pulse, or read bits shifted by one position, and the bench sees it at the ninth SCL sample of the same byte. A wrong address counter or page offset stays hidden until the next read, which then returns a byte from the wrong location. A staging buffer that commits early, late or on an aborted transfer shows up in one of two ways: as a changed byte in the later read-back, or as a busy NACK on the poll that follows the STOP within one byte time. Any drive change during SCL high is caught by the per-clock monitor in the same cycle.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int CNT_W    = 4;
    localparam logic [CNT_W-1:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WORD,
        ST_ACK_WORD,
        ST_WRDATA,
        ST_ACK_DATA,
        ST_RDDATA,
        ST_RDACK,
        ST_WAIT
    } ee_state_t;
endpackage

// File: rtl/eeprom_bus_sense.sv
module eeprom_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] clean;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    // one synchroniser chain per bus line; lines idle high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
            end
        end
        assign clean[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= clean;
        end
    end

    assign scl_s     = clean[1];
    assign sda_s     = clean[0];
    assign scl_rise  = clean[1] & ~prev_q[1];
    assign scl_fall  = ~clean[1] & prev_q[1];
    assign start_det = clean[1] & prev_q[1] & prev_q[0] & ~clean[0];
    assign stop_det  = clean[1] & prev_q[1] & ~prev_q[0] & clean[0];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CW'(BUSY_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array
    import eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [BYTE_W-1:0]                    rd_data,
    input  logic                                 wr_en,
    input  logic [ADDR_W-PAGE_W-1:0]             wr_page,
    input  logic [(1<<PAGE_W)-1:0]               wr_mask,
    input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0]   wr_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PAGE_SEL_W = ADDR_W - PAGE_W;

    logic [DEPTH*BYTE_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int PG = g / PAGE_BYTES;
        localparam int OF = g % PAGE_BYTES;
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '1;
            end else if (wr_en && wr_page == PAGE_SEL_W'(PG) && wr_mask[OF]) begin
                q <= wr_data[OF];
            end
        end
        assign flat[g*BYTE_W +: BYTE_W] = q;
    end

    assign rd_data = flat[rd_addr*BYTE_W +: BYTE_W];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    input  logic               wr_permit_i,
    output logic               sda_pull_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PAGE_SEL_W = ADDR_W - PAGE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy;

    ee_state_t                          state_q, state_d;
    logic [CNT_W-1:0]                   cnt_q;
    logic [BYTE_W-1:0]                  shreg_q;
    logic [ADDR_W-1:0]                  ctr_q;
    logic                               rd_dir_q;
    logic                               wp_ok_q;
    logic                               mack_q;
    logic                               commit_q;
    logic [PAGE_BYTES-1:0]              pmask_q;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0]  pbuf_q;
    logic [BYTE_W-1:0]                  rd_data;
    logic                               dev_match;
    logic                               byte_done;

    eeprom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_q),
        .busy  (busy)
    );

    eeprom_cell_array #(.PAGE_W(PAGE_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ctr_q),
        .rd_data (rd_data),
        .wr_en   (commit_q),
        .wr_page (ctr_q[ADDR_W-1:PAGE_W]),
        .wr_mask (pmask_q),
        .wr_data (pbuf_q)
    );

    assign dev_match = (shreg_q[BYTE_W-1:BYTE_W-4] == DEV_TYPE) &&
                       (shreg_q[STRAP_W:1] == strap_i) && !busy;
    assign byte_done = scl_fall && (cnt_q == BITS_PER_BYTE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_DEV:      if (byte_done) state_d = dev_match ? ST_ACK_DEV : ST_WAIT;
                ST_ACK_DEV:  if (scl_fall)  state_d = rd_dir_q ? ST_RDDATA : ST_WORD;
                ST_WORD:     if (byte_done) state_d = ST_ACK_WORD;
                ST_ACK_WORD: if (scl_fall)  state_d = ST_WRDATA;
                ST_WRDATA:   if (byte_done) state_d = wp_ok_q ? ST_ACK_DATA : ST_WAIT;
                ST_ACK_DATA: if (scl_fall)  state_d = ST_WRDATA;
                ST_RDDATA:   if (byte_done) state_d = ST_RDACK;
                ST_RDACK:    if (scl_fall)  state_d = mack_q ? ST_RDDATA : ST_WAIT;
                default:     state_d = state_q;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            shreg_q  <= '0;
            ctr_q    <= '0;
            rd_dir_q <= 1'b0;
            wp_ok_q  <= 1'b0;
            mack_q   <= 1'b0;
            commit_q <= 1'b0;
            pmask_q  <= '0;
            pbuf_q   <= '0;
        end else begin
            state_q  <= state_d;
            commit_q <= 1'b0;
            if (commit_q) begin
                pmask_q <= '0;
            end
            if (start_det) begin
                cnt_q   <= '0;
                pmask_q <= '0;
            end else if (stop_det) begin
                cnt_q <= '0;
                // one SCL rise always precedes a STOP; two or more mean a broken byte
                if (state_q == ST_WRDATA && cnt_q <= 4'd1 && |pmask_q) begin
                    commit_q <= 1'b1;
                end else begin
                    pmask_q <= '0;
                end
            end else begin
                unique case (state_q)
                    ST_DEV, ST_WORD, ST_WRDATA: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 4'd1;
                        end
                        if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == ST_DEV) begin
                                rd_dir_q <= shreg_q[0];
                            end else if (state_q == ST_WORD) begin
                                ctr_q <= shreg_q;
                            end else if (wp_ok_q) begin
                                pbuf_q[ctr_q[PAGE_W-1:0]]  <= shreg_q;
                                pmask_q[ctr_q[PAGE_W-1:0]] <= 1'b1;
                                ctr_q <= {ctr_q[ADDR_W-1:PAGE_W],
                                          PAGE_W'(ctr_q[PAGE_W-1:0] + 1'b1)};
                            end
                        end
                    end
                    ST_ACK_DEV: begin
                        if (scl_fall && rd_dir_q) begin
                            shreg_q <= rd_data;
                            ctr_q   <= ctr_q + 8'd1;
                            cnt_q   <= '0;
                        end
                    end
                    ST_ACK_WORD: begin
                        if (scl_fall) begin
                            wp_ok_q <= !wp_i && wr_permit_i;
                        end
                    end
                    ST_RDDATA: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (scl_fall && cnt_q != BITS_PER_BYTE) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            mack_q <= !sda_s;
                        end
                        if (scl_fall && mack_q) begin
                            shreg_q <= rd_data;
                            ctr_q   <= ctr_q + 8'd1;
                            cnt_q   <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_ACK_DEV, ST_ACK_WORD, ST_ACK_DATA: sda_pull_o = 1'b1;
            ST_RDDATA:                            sda_pull_o = ~shreg_q[BYTE_W-1];
            default:                              sda_pull_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_eeprom_checker.sv
module serial_eeprom_checker
    import eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               start_det,
    input logic               stop_det,
    input logic               sda_pull_o,
    input logic               busy,
    input logic               commit_q,
    input ee_state_t          state_q,
    input logic [ADDR_W-1:0]  ctr_q,
    input logic [BYTE_W-1:0]  shreg_q,
    input logic [STRAP_W-1:0] strap_i
);
    // R1: entering the device acknowledge needs the type code and the straps
    assert_dev_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DEV && $past(state_q) != ST_ACK_DEV) |->
        (shreg_q[BYTE_W-1:1] == {DEV_TYPE, strap_i}));

    // R4: staged data reaches the array only right after a STOP
    assert_commit_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(stop_det));

    // R4: accepting a data byte never moves the counter out of its page
    assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DATA && $past(state_q) != ST_ACK_DATA) |->
        (ctr_q[ADDR_W-1:PAGE_W] == $past(ctr_q[ADDR_W-1:PAGE_W])));

    // R5: a commit starts the busy period
    assert_busy_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> busy);

    // R5: no device acknowledge while busy
    assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state_q != ST_ACK_DEV);

    // R13: drive steady while SCL stays high outside START/STOP
    assert_pull_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_det && !stop_det &&
         !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull_o));
endmodule

bind serial_eeprom_slave serial_eeprom_checker #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .busy       (busy),
    .commit_q   (commit_q),
    .state_q    (state_q),
    .ctr_q      (ctr_q),
    .shreg_q    (shreg_q),
    .strap_i    (strap_i)
);

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
    localparam int BUSY = 300;
    localparam logic [2:0] MY_STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       permit = 1'b1;
    logic       sda_pull;
    logic       sda_line;

    int vectors = 0;
    int miscompares = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    logic [7:0] mem_m [256];
    logic [7:0] ctr_m;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    serial_eeprom_slave #(.BUSY_CYCLES(BUSY)) u_serial_eeprom_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .strap_i     (MY_STRAP),
        .wp_i        (wp),
        .wr_permit_i (permit),
        .sda_pull_o  (sda_pull)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R13 monitor: drive must not move while SCL is held high
    logic prev_scl = 1'b0, prev_sda_m = 1'b1, prev_pull = 1'b0;
    always @(negedge clk) begin
        if (mon_on && scl && prev_scl && sda_m == prev_sda_m) begin
            chk("R13 pull steady while SCL high", sda_pull, prev_pull);
        end
        prev_scl   <= scl;
        prev_sda_m <= sda_m;
        prev_pull  <= sda_pull;
    end

    task automatic qw();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = !sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
        end
        sda_m = !mack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic poll(input logic exp_ack, input string tag);
        logic a;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, a);
        chk(tag, a, exp_ack);
        bus_stop();
    endtask

    task automatic read_seq(input int n, input string tag);
        logic [7:0] got;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, got);
            chk(tag, got, mem_m[ctr_m]);
            ctr_m = ctr_m + 8'd1;
        end
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] addr, input int n, input string tag);
        logic a;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, a); chk({tag, " dev ack"}, a, 1);
        send_byte(addr, a);                      chk({tag, " addr ack"}, a, 1);
        ctr_m = addr;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b1}, a); chk({tag, " rd dev ack"}, a, 1);
        read_seq(n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic a;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b1}, a); chk({tag, " rd dev ack"}, a, 1);
        read_seq(n, tag);
    endtask

    // write n bytes base+i from addr; exp_ok is the expected first data ack
    task automatic write_txn(input logic [7:0] addr, input int n, input logic [7:0] base,
                             input logic exp_ok, input bit late_wp, input string tag);
        logic a;
        logic [7:0] p;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, a); chk({tag, " R2 dev ack"}, a, 1);
        send_byte(addr, a);                      chk({tag, " R2 addr ack"}, a, 1);
        if (late_wp) begin qw(); wp = 1'b1; end
        p = addr;
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), a);
            chk({tag, " data ack"}, a, exp_ok);
            if (!exp_ok) break;
            mem_m[p] = base + 8'(i);
            p = {p[7:4], 4'(p[3:0] + 4'd1)};
        end
        bus_stop();
        ctr_m = p;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        logic a;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        ctr_m = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 pull low after reset", sda_pull, 0);
        mon_on = 1'b1;

        // R11 fresh contents, R7 random read
        random_read(8'h10, 2, "R11 erased read");

        // R1 wrong straps, wrong type code
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, a); chk("R1 wrong strap nack", a, 0); bus_stop();
        bus_start(); send_byte({4'b1011, MY_STRAP, 1'b0}, a); chk("R1 wrong type nack", a, 0); bus_stop();

        // R3 byte write, R5 busy polling
        write_txn(8'h00, 1, 8'h11, 1'b1, 1'b0, "R3 byte write");
        poll(1'b0, "R5 busy nack");
        repeat (BUSY + 60) @(negedge clk);
        poll(1'b1, "R5 ready ack");

        write_txn(8'h05, 1, 8'h3C, 1'b1, 1'b0, "R3 byte write 05");
        repeat (BUSY + 60) @(negedge clk);
        random_read(8'h05, 1, "R7 random read 05");
        cur_read(1, "R6 current read 06");

        // R4 page write of 20 bytes wraps inside page 0x20
        write_txn(8'h2E, 20, 8'h80, 1'b1, 1'b0, "R4 page write");
        repeat (BUSY + 60) @(negedge clk);
        cur_read(1, "R6 counter after page write");
        random_read(8'h20, 17, "R4 page contents");

        // R8 sequential read wraps over the end of memory
        random_read(8'hFE, 3, "R8 wrap read");
        cur_read(1, "R6 counter after wrap");

        // R9 WP high at the strobe
        wp = 1'b1;
        write_txn(8'h40, 1, 8'h5A, 1'b0, 1'b0, "R9 wp reject");
        wp = 1'b0;
        poll(1'b1, "R9 no busy after reject");
        random_read(8'h40, 1, "R9 unchanged");

        // R9 WP rising after the strobe does not block
        write_txn(8'h41, 1, 8'h6B, 1'b1, 1'b1, "R9 late wp");
        wp = 1'b0;
        repeat (BUSY + 60) @(negedge clk);
        random_read(8'h41, 1, "R9 late wp written");

        // R10 permit low at the strobe
        permit = 1'b0;
        write_txn(8'h42, 1, 8'h7C, 1'b0, 1'b0, "R10 permit reject");
        permit = 1'b1;
        poll(1'b1, "R10 no busy after reject");
        random_read(8'h42, 1, "R10 unchanged");

        // R12 STOP in the middle of a byte
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, a); chk("R12 dev ack", a, 1);
        send_byte(8'h50, a);                     chk("R12 addr ack", a, 1);
        send_byte(8'h77, a);                     chk("R12 data ack", a, 1);
        send_bits(8'hA0, 4);
        bus_stop();
        poll(1'b1, "R12 no busy after stop abort");
        random_read(8'h50, 1, "R12 stop abort unchanged");

        // R12 START in the middle of a byte
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, a); chk("R12 dev ack 2", a, 1);
        send_byte(8'h60, a);                     chk("R12 addr ack 2", a, 1);
        send_byte(8'h12, a);                     chk("R12 data ack 2", a, 1);
        send_bits(8'hC0, 3);
        bus_start();
        bus_stop();
        poll(1'b1, "R12 no busy after start abort");
        random_read(8'h60, 1, "R12 start abort unchanged");

        mon_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule